// File: doc/BRIEF.md
# Tracking Position Counter with Resolution Select

This block holds the digital angle of a tracking loop as a 16-bit up/down register. Each single-cycle tracking strobe moves the angle by one step in the direction given with the strobe. The step is one LSB of the currently selected resolution. Every accepted strobe runs a fixed sequence. First the direction output is set and held for a lead time. Then a busy pulse of fixed length is raised, and the angle register moves a set number of cycles after the busy pulse rises. All three durations are parameters counted in clock cycles.

A two-bit code selects a 10-, 12-, 14- or 16-bit effective width. The code is sampled only on the cycle the busy pulse ends, so the width never changes in the middle of an update. Bits below the active LSB always read as zero. An active-low major-carry output, computed over the active bits only, works with the direction output so that an external turns counter can be cascaded. A strobe that arrives while an update is in progress is held in a single pending slot and served after the busy pulse ends. Further strobes that arrive while the slot is full are discarded.

Top module: `trk_pos_counter`

## Requirements
- R1: The step added or subtracted is one LSB of the active width. On the 16-bit `angle_o` this is 0x0040 for 10 bits, 0x0010 for 12 bits, 0x0004 for 14 bits and 0x0001 for 16 bits. The active width comes from the resolution code as 00=10, 01=12, 10=14 and 11=16 bits.
- R2: `res_sel_i` is sampled only on the clock edge where `busy_o` falls, and the sampled width applies from that edge onward. After reset the active width is 16 bits.
- R3: An accepted strobe is followed by `DIR_LEAD` cycles with `busy_o` low. `busy_o` is then high for exactly `BUSY_LEN` cycles.
- R4: `angle_o` changes exactly `UPD_DELAY` cycles after `busy_o` rises. It changes at no other time, except for the re-masking that occurs when the width changes.
- R5: `dir_o` takes the direction of the strobe being served (1 = up, 0 = down) on the accept edge. It holds that value through the lead time and the whole busy pulse, whatever `dir_i` does.
- R6: `major_carry_o` is low exactly when the active bits are all ones with `dir_o`=1, or all zeros with `dir_o`=0. Otherwise it is high.
- R7: Bits of `angle_o` below the active LSB always read as 0, including right after the width is reduced.
- R8: A strobe arriving during the lead time or the busy pulse is held and served after `busy_o` falls. A further strobe arriving while one is already held is discarded.
- R9: The count wraps modulo the active width: up from all ones gives 0, and down from 0 gives all ones.
- R10: During reset `angle_o` is 0, `busy_o` is 0, `dir_o` is 1 and `major_carry_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trk_pulse_i | input | 1 | Single-cycle tracking strobe |
| dir_i | input | 1 | Direction for the strobe, 1 = up |
| res_sel_i | input | 2 | Resolution code |
| busy_o | output | 1 | Update-in-progress pulse |
| dir_o | output | 1 | Direction of the update being served |
| major_carry_o | output | 1 | Active-low carry at the active width |
| angle_o | output | 16 | Angle, MSB-aligned, unused LSBs zero |

## Verification
The hardest situation to reach is the single pending slot. It is occupied only when a second strobe lands inside the lead or busy window, and it is overrun only when a third strobe lands before the first update finishes. The bench places strobes at fixed cycle offsets from the first one. It gives the pending and the discarded strobes opposite directions, so the final angle shows whether the slot was served, overwritten or queued twice. Width capture is checked in a similar way. A new code is applied while the block is idle, and the two updates that follow must use the old width and then the new one.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int ANGLE_W = 16;
  localparam int RES_N   = 4;

  typedef enum logic [1:0] {RES_10 = 2'b00, RES_12 = 2'b01, RES_14 = 2'b10, RES_16 = 2'b11} res_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_BUSY} seq_e;

  function automatic logic [ANGLE_W-1:0] res_step(res_e r);
    int bits;
    logic [ANGLE_W-1:0] one;
    bits = 10 + 2 * int'(r);
    one  = 1;
    return one << (ANGLE_W - bits);
  endfunction

  function automatic logic [ANGLE_W-1:0] res_mask(res_e r);
    return ~(res_step(r) - ANGLE_W'(1));
  endfunction
endpackage

// File: rtl/trk_seq.sv
module trk_seq #(
  parameter int DIR_LEAD  = 4,
  parameter int BUSY_LEN  = 8,
  parameter int UPD_DELAY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic dir_i,
  output logic busy_o,
  output logic dir_o,
  output logic upd_o,
  output logic busy_end_o
);
  import trk_pkg::*;
  localparam int MAXLEN = (BUSY_LEN > DIR_LEAD) ? BUSY_LEN : DIR_LEAD;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  seq_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic dir_q, dir_d, pend_q, pend_d, pdir_q, pdir_d;
  logic lead_done, busy_done;

  assign lead_done = (state_q == SQ_LEAD) && (cnt_q == CNT_W'(DIR_LEAD - 1));
  assign busy_done = (state_q == SQ_BUSY) && (cnt_q == CNT_W'(BUSY_LEN - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    pend_d  = pend_q;
    pdir_d  = pdir_q;
    unique case (state_q)
      SQ_IDLE: if (pulse_i) begin
        state_d = SQ_LEAD;
        cnt_d   = '0;
        dir_d   = dir_i;
      end
      SQ_LEAD: begin
        if (pulse_i && !pend_q) begin
          pend_d = 1'b1;
          pdir_d = dir_i;
        end
        if (lead_done) begin
          state_d = SQ_BUSY;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      SQ_BUSY: begin
        if (pulse_i && !pend_q) begin
          pend_d = 1'b1;
          pdir_d = dir_i;
        end
        if (busy_done) begin
          cnt_d = '0;
          if (pend_q) begin
            // serve held strobe; a strobe on this edge takes the slot
            state_d = SQ_LEAD;
            dir_d   = pdir_q;
            pend_d  = pulse_i;
            pdir_d  = dir_i;
          end else if (pulse_i) begin
            state_d = SQ_LEAD;
            dir_d   = dir_i;
            pend_d  = 1'b0;
          end else state_d = SQ_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      pend_q  <= 1'b0;
      pdir_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      pend_q  <= pend_d;
      pdir_q  <= pdir_d;
    end
  end

  assign busy_o     = (state_q == SQ_BUSY);
  assign dir_o      = dir_q;
  assign upd_o      = (state_q == SQ_BUSY) && (cnt_q == CNT_W'(UPD_DELAY - 1));
  assign busy_end_o = busy_done;
endmodule

// File: rtl/trk_res_reg.sv
module trk_res_reg import trk_pkg::*; #(
  parameter logic [1:0] RES_RST = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] res_i,
  output res_e       res_o
);
  res_e res_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= res_e'(RES_RST);
    else if (load_i) res_q <= res_e'(res_i);
  end
  assign res_o = res_q;
endmodule

// File: rtl/trk_angle_ctr.sv
module trk_angle_ctr import trk_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               up_i,
  input  res_e               res_i,
  output logic [ANGLE_W-1:0] angle_o,
  output logic               major_carry_o
);
  logic [ANGLE_W-1:0] step_tbl [RES_N];
  logic [ANGLE_W-1:0] cnt_q, step, mask, base;

  for (genvar g = 0; g < RES_N; g++) begin : g_step
    assign step_tbl[g] = res_step(res_e'(g));
  end

  assign step = step_tbl[res_i];
  assign mask = ~(step - ANGLE_W'(1));
  assign base = cnt_q & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (upd_i) cnt_q <= up_i ? base + step : base - step;
  end

  assign angle_o       = base;
  assign major_carry_o = ~(up_i ? (base == mask) : (base == '0));
endmodule

// File: rtl/trk_pos_counter.sv
module trk_pos_counter import trk_pkg::*; #(
  parameter int         DIR_LEAD  = 4,
  parameter int         BUSY_LEN  = 8,
  parameter int         UPD_DELAY = 2,
  parameter logic [1:0] RES_RST   = 2'b11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trk_pulse_i,
  input  logic               dir_i,
  input  logic [1:0]         res_sel_i,
  output logic               busy_o,
  output logic               dir_o,
  output logic               major_carry_o,
  output logic [ANGLE_W-1:0] angle_o
);
  logic upd, busy_end;
  res_e res_act;

  trk_seq #(.DIR_LEAD(DIR_LEAD), .BUSY_LEN(BUSY_LEN), .UPD_DELAY(UPD_DELAY)) u_seq (
    .clk_i, .rst_ni, .pulse_i(trk_pulse_i), .dir_i,
    .busy_o, .dir_o, .upd_o(upd), .busy_end_o(busy_end)
  );

  trk_res_reg #(.RES_RST(RES_RST)) u_res (
    .clk_i, .rst_ni, .load_i(busy_end), .res_i(res_sel_i), .res_o(res_act)
  );

  trk_angle_ctr u_ctr (
    .clk_i, .rst_ni, .upd_i(upd), .up_i(dir_o), .res_i(res_act),
    .angle_o, .major_carry_o
  );
endmodule

// File: rtl/trk_pos_counter_chk.sv
module trk_pos_counter_chk import trk_pkg::*; #(
  parameter int         BUSY_LEN = 8,
  parameter logic [1:0] RES_RST  = 2'b11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         res_sel_i,
  input logic               busy_o,
  input logic               dir_o,
  input logic               major_carry_o,
  input logic [ANGLE_W-1:0] angle_o
);
  localparam int BL_W = $clog2(BUSY_LEN + 2);
  logic [BL_W-1:0] bl_q;
  logic busy_q;
  logic [1:0] res_prev_q, res_trk_q, res_cur;
  logic [ANGLE_W-1:0] cmask, cstep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_q <= '0; busy_q <= 1'b0; res_prev_q <= RES_RST; res_trk_q <= RES_RST;
    end else begin
      bl_q       <= busy_o ? bl_q + 1'b1 : '0;
      busy_q     <= busy_o;
      res_prev_q <= res_sel_i;
      res_trk_q  <= res_cur;
    end
  end

  assign res_cur = (busy_q && !busy_o) ? res_prev_q : res_trk_q;
  assign cstep   = res_step(res_e'(res_cur));
  assign cmask   = res_mask(res_e'(res_cur));

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bl_q == BL_W'(BUSY_LEN));
  assert_quiet_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(angle_o));
  assert_dir_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(dir_o));
  assert_step_size_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && angle_o != $past(angle_o)) |->
      angle_o == (dir_o ? $past(angle_o) + cstep : $past(angle_o) - cstep));
  assert_low_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (angle_o & ~cmask) == '0);
  assert_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !major_carry_o |-> (dir_o ? angle_o == cmask : angle_o == '0));
endmodule

bind trk_pos_counter trk_pos_counter_chk #(.BUSY_LEN(BUSY_LEN), .RES_RST(RES_RST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .res_sel_i(res_sel_i), .busy_o(busy_o),
  .dir_o(dir_o), .major_carry_o(major_carry_o), .angle_o(angle_o)
);

// File: tb/trk_pos_counter_tb.sv
`timescale 1ns/1ps
module trk_pos_counter_tb;
  localparam int DIR_LEAD = 4, BUSY_LEN = 8, UPD_DELAY = 2;
  localparam int SETTLE = DIR_LEAD + BUSY_LEN + 3;

  logic clk = 1'b0, rst_ni = 1'b0, trk_pulse_i = 1'b0, dir_i = 1'b1;
  logic [1:0] res_sel_i = 2'b11;
  logic busy_o, dir_o, major_carry_o;
  logic [15:0] angle_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  trk_pos_counter #(.DIR_LEAD(DIR_LEAD), .BUSY_LEN(BUSY_LEN), .UPD_DELAY(UPD_DELAY)) u_dut (
    .clk_i(clk), .rst_ni, .trk_pulse_i, .dir_i, .res_sel_i,
    .busy_o, .dir_o, .major_carry_o, .angle_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic d);
    @(negedge clk); trk_pulse_i = 1'b1; dir_i = d;
    @(negedge clk); trk_pulse_i = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_to(input logic d, input logic [15:0] exp, input string req);
    send(d); settle(SETTLE);
    check(angle_o == exp, req, angle_o, exp);
  endtask

  task automatic t_reset;
    check(angle_o == 16'h0 && busy_o == 1'b0, "R10 angle/busy", {angle_o, 15'b0, busy_o}, 32'h0);
    check(dir_o == 1'b1 && major_carry_o == 1'b1, "R10 dir/carry", {dir_o, major_carry_o}, 2'b11);
  endtask

  // R3 R4 R5: cycle-exact sequence for one up step at 16 bits
  task automatic t_timing;
    int bad_busy = 0, bad_ang = 0, bad_dir = 0;
    @(negedge clk); trk_pulse_i = 1'b1; dir_i = 1'b1;
    for (int k = 1; k <= DIR_LEAD + BUSY_LEN + 1; k++) begin
      @(negedge clk);
      trk_pulse_i = 1'b0;
      dir_i = k[0];
      if (busy_o != ((k > DIR_LEAD) && (k <= DIR_LEAD + BUSY_LEN))) bad_busy++;
      if (angle_o != ((k > DIR_LEAD + UPD_DELAY) ? 16'h0001 : 16'h0000)) bad_ang++;
      if (dir_o != 1'b1) bad_dir++;
    end
    check(bad_busy == 0, "R3 busy window", bad_busy, 0);
    check(bad_ang == 0, "R4 update cycle", bad_ang, 0);
    check(bad_dir == 0, "R5 dir hold", bad_dir, 0);
    settle(2);
  endtask

  task automatic t_wrap16;
    step_to(1'b0, 16'h0000, "R1 16b down");
    check(major_carry_o == 1'b0, "R6 zero down", major_carry_o, 0);
    step_to(1'b0, 16'hFFFF, "R9 16b wrap down");
    check(major_carry_o == 1'b1, "R6 ones down", major_carry_o, 1);
    step_to(1'b1, 16'h0000, "R9 16b wrap up");
    check(major_carry_o == 1'b1, "R6 zero up", major_carry_o, 1);
  endtask

  task automatic t_res_capture;
    res_sel_i = 2'b00;
    step_to(1'b1, 16'h0000, "R2 old width then R7 mask");
    step_to(1'b1, 16'h0040, "R2 new width / R1 10b");
    res_sel_i = 2'b01;
    step_to(1'b1, 16'h0080, "R2 10b kept");
    step_to(1'b1, 16'h0090, "R1 12b step");
    res_sel_i = 2'b10;
    step_to(1'b1, 16'h00A0, "R2 12b kept");
    step_to(1'b1, 16'h00A4, "R1 14b step");
    res_sel_i = 2'b11;
    step_to(1'b1, 16'h00A8, "R2 14b kept");
    step_to(1'b1, 16'h00A9, "R1 16b step");
  endtask

  task automatic t_carry10;
    res_sel_i = 2'b00;
    step_to(1'b0, 16'h0080, "R7 reduce width");
    step_to(1'b0, 16'h0040, "R1 10b down");
    step_to(1'b0, 16'h0000, "R1 10b down");
    check(major_carry_o == 1'b0, "R6 10b zero down", major_carry_o, 0);
    step_to(1'b0, 16'hFFC0, "R9 10b wrap down");
    check(major_carry_o == 1'b1, "R6 10b down nonzero", major_carry_o, 1);
    send(1'b1);
    check(dir_o == 1'b1 && major_carry_o == 1'b0, "R6 10b ones up", {dir_o, major_carry_o}, 2'b10);
    settle(SETTLE);
    check(angle_o == 16'h0000, "R9 10b wrap up", angle_o, 16'h0);
  endtask

  task automatic t_pending;
    // one held strobe is served
    send(1'b1);
    settle(DIR_LEAD + 2);
    send(1'b1);
    settle(2 * SETTLE);
    check(angle_o == 16'h0080, "R8 held served", angle_o, 16'h0080);
    // held down served, third strobe discarded
    send(1'b1);
    @(negedge clk); trk_pulse_i = 1'b1; dir_i = 1'b0;
    @(negedge clk); dir_i = 1'b1;
    @(negedge clk); trk_pulse_i = 1'b0;
    settle(3 * SETTLE);
    check(angle_o == 16'h0080, "R8 overflow dropped", angle_o, 16'h0080);
    check(busy_o == 1'b0, "R8 idle after", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    settle(2);
    t_timing();
    t_wrap16();
    t_res_capture();
    t_carry10();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule